// File: doc/BRIEF.md
# Flash Sector Read-Modify-Write Engine

This block serves 512-byte logical block reads and writes on a byte-wide flash array that can only be erased in 4096-byte sectors. Each sector therefore holds eight logical blocks. A read streams the 512 bytes of the addressed block out of flash in ascending order. No erase and no staging take part in a read.

A write cannot patch a block in place. The engine first copies the whole enclosing sector into a local staging RAM. It then takes the 512 new bytes from the requester into the block's slot of that copy. Next it erases the sector. Last, it programs all 4096 bytes back, one byte at a time, waiting for the flash to report idle after each byte. A single block write thus always costs 4096 byte programs.

Requests use a valid/ready port carrying a block number and a read/write flag. Write data enters on a byte stream with valid/ready. Read data leaves on a byte stream that has a valid flag and no backpressure. A one-cycle done pulse marks the end of every operation.

Top module: `sector_rmw_engine`

## Requirements
- R1: During and after reset, reqReady is high and outValid, done, inReady, flRead, flErase and flProg are all low.
- R2: A read of block b drives flRead on exactly 512 ascending flash addresses starting at b*512. outData carries each byte with outValid one cycle after its flRead. The read issues no erase and no program.
- R3: For a write of block b, the sector is b/8 and the slot is b%8. The engine reads all 4096 sector bytes before anything else. It then accepts the 512 new bytes. Next it issues one erase at the sector base, and after that it programs the sector addresses in ascending order. No flash read happens after the erase.
- R4: An erase or a byte program is issued only while flBusy is low. The engine waits for flBusy to fall before issuing the next program. flBusy must rise in the cycle after an erase or program strobe.
- R5: After a write, slot b%8 of the sector holds the new bytes in stream order. The other seven blocks of the sector and all other sectors keep their previous contents.
- R6: One block write issues exactly 4096 byte programs, and no byte is programmed twice without an erase in between.
- R7: reqReady is low from the cycle after a request is accepted until the operation finishes. A request presented in that window is ignored: it starts no flash access and produces no output.
- R8: done is a single-cycle pulse after the last read byte has been presented, or after the last program has completed. reqReady is high in the following cycle.
- R9: inReady is high only in the merge phase. It holds while inValid is low, so gaps in the write stream lose no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = block write, 0 = block read |
| reqBlock | input | BLK_W (5) | Logical block number |
| reqReady | output | 1 | Engine idle, request accepted when valid |
| inValid | input | 1 | Write byte present |
| inData | input | 8 | Write byte |
| inReady | output | 1 | Engine takes write byte this cycle |
| outValid | output | 1 | Read byte present |
| outData | output | 8 | Read byte |
| done | output | 1 | Operation finished (one-cycle pulse) |
| flAddr | output | ADDR_W (14) | Flash byte address |
| flRead | output | 1 | Flash read strobe, data one cycle later |
| flRdData | input | 8 | Flash read data |
| flErase | output | 1 | Sector erase strobe (address = sector base) |
| flProg | output | 1 | Byte program strobe |
| flWrData | output | 8 | Byte to program |
| flBusy | input | 1 | Flash erase or program in progress |

## Verification
Reads cover a block with untouched preset data, blocks that were just rewritten, and a neighbour of a rewritten block in the same sector. Together these separate correct slot placement from a shifted or overwritten slot. Writes target the first slot of one sector and the last slot of another, to expose sector/slot split errors at both ends. A third write feeds the data stream with idle gaps, which separates real handshake stalling from byte dropping. The flash model reports reads after the erase, out-of-order or repeated programs, and strobes issued while busy. Stray requests during a write must leave the flash traffic counts unchanged.

// File: rtl/sector_rmw_pkg.sv
package sector_rmw_pkg;

  typedef struct packed {
    logic latchReq;  // capture block number, clear counter
    logic cntClr;
    logic cntInc;
    logic blkRd;     // flash read inside the block (read op)
    logic secRd;     // flash read inside the sector (copy phase)
    logic mergeWr;   // write stream byte into staging slot
    logic erase;
    logic prog;
    logic stageRd;   // fetch staging byte for programming
  } strobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_DRAIN,
    ST_CP,
    ST_CP_DRAIN,
    ST_MERGE,
    ST_ERASE,
    ST_E_SET,
    ST_E_WAIT,
    ST_P_FETCH,
    ST_P_ISSUE,
    ST_P_SET,
    ST_P_WAIT,
    ST_DONE
  } state_t;

endpackage

// File: rtl/sector_rmw_ctrl.sv
module sector_rmw_ctrl
  import sector_rmw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  input  logic    inValid,
  output logic    inReady,
  input  logic    flBusy,
  input  logic    cntLastBlk,
  input  logic    cntLastSec,
  output logic    done,
  output strobe_t st
);

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    st        = '0;
    reqReady  = 1'b0;
    inReady   = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          st.latchReq = 1'b1;
          st.cntClr   = 1'b1;
          stateNext   = reqWrite ? ST_CP : ST_RD;
        end
      end
      ST_RD: begin
        st.blkRd  = 1'b1;
        st.cntInc = 1'b1;
        if (cntLastBlk) stateNext = ST_RD_DRAIN;
      end
      ST_RD_DRAIN: stateNext = ST_DONE;
      ST_CP: begin
        st.secRd  = 1'b1;
        st.cntInc = 1'b1;
        if (cntLastSec) stateNext = ST_CP_DRAIN;
      end
      ST_CP_DRAIN: begin
        st.cntClr = 1'b1;
        stateNext = ST_MERGE;
      end
      ST_MERGE: begin
        inReady = 1'b1;
        if (inValid) begin
          st.mergeWr = 1'b1;
          if (cntLastBlk) begin
            st.cntClr = 1'b1;
            stateNext = ST_ERASE;
          end else begin
            st.cntInc = 1'b1;
          end
        end
      end
      ST_ERASE: begin
        if (!flBusy) begin
          st.erase  = 1'b1;
          stateNext = ST_E_SET;
        end
      end
      ST_E_SET: stateNext = ST_E_WAIT;
      ST_E_WAIT: if (!flBusy) stateNext = ST_P_FETCH;
      ST_P_FETCH: begin
        st.stageRd = 1'b1;
        stateNext  = ST_P_ISSUE;
      end
      ST_P_ISSUE: begin
        st.prog   = 1'b1;
        stateNext = ST_P_SET;
      end
      ST_P_SET: stateNext = ST_P_WAIT;
      ST_P_WAIT: begin
        if (!flBusy) begin
          if (cntLastSec) begin
            stateNext = ST_DONE;
          end else begin
            st.cntInc = 1'b1;
            stateNext = ST_P_FETCH;
          end
        end
      end
      ST_DONE: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  AST_PROG_FLASH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    st.prog |-> !flBusy);                                     // R4
  AST_ERASE_FLASH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    st.erase |-> !flBusy);                                    // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                          // R8
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> reqReady);                                       // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    st.latchReq |=> !reqReady);                               // R7

endmodule

// File: rtl/sector_rmw_datapath.sv
module sector_rmw_datapath
  import sector_rmw_pkg::*;
#(
  parameter int BLOCK_BYTES  = 512,
  parameter int SECTOR_BYTES = 4096,
  parameter int NUM_SECTORS  = 4,
  localparam int OFF_W     = $clog2(BLOCK_BYTES),
  localparam int SEC_OFF_W = $clog2(SECTOR_BYTES),
  localparam int SLOT_W    = SEC_OFF_W - OFF_W,
  localparam int SEC_W     = $clog2(NUM_SECTORS),
  localparam int BLK_W     = SEC_W + SLOT_W,
  localparam int ADDR_W    = SEC_W + SEC_OFF_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  logic [BLK_W-1:0]  reqBlock,
  input  logic [7:0]        inData,
  input  logic [7:0]        flRdData,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flWrData,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              cntLastBlk,
  output logic              cntLastSec
);

  logic [BLK_W-1:0]     blkQ;
  logic [SEC_OFF_W-1:0] cnt;
  logic                 cpWe;
  logic [SEC_OFF_W-1:0] cpAddr;
  logic [7:0]           stageQ;
  logic [7:0]           stage [SECTOR_BYTES];

  logic [SEC_W-1:0]  secIdx;
  logic [SLOT_W-1:0] slot;

  assign secIdx = blkQ[BLK_W-1:SLOT_W];
  assign slot   = blkQ[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blkQ     <= '0;
      cnt      <= '0;
      cpWe     <= 1'b0;
      cpAddr   <= '0;
      outValid <= 1'b0;
    end else begin
      if (st.latchReq) blkQ <= reqBlock;
      if (st.cntClr)      cnt <= '0;
      else if (st.cntInc) cnt <= cnt + SEC_OFF_W'(1);
      cpWe     <= st.secRd;
      cpAddr   <= cnt;
      outValid <= st.blkRd;
    end
  end

  // staging RAM: one write port shared by copy and merge, one read port
  always_ff @(posedge clk) begin
    if (cpWe)            stage[cpAddr] <= flRdData;
    else if (st.mergeWr) stage[{slot, cnt[OFF_W-1:0]}] <= inData;
    if (st.stageRd)      stageQ <= stage[cnt];
  end

  assign flAddr     = st.blkRd ? {secIdx, slot, cnt[OFF_W-1:0]} : {secIdx, cnt};
  assign flWrData   = stageQ;
  assign outData    = flRdData;
  assign cntLastBlk = (cnt[OFF_W-1:0] == '1);
  assign cntLastSec = (cnt == '1);

  AST_STAGE_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    cpWe |-> !st.mergeWr);                                    // R3
  AST_OUT_NOT_DURING_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !cpWe);                                      // R2

endmodule

// File: rtl/sector_rmw_engine.sv
module sector_rmw_engine
  import sector_rmw_pkg::*;
#(
  parameter int BLOCK_BYTES  = 512,
  parameter int SECTOR_BYTES = 4096,
  parameter int NUM_SECTORS  = 4,
  localparam int OFF_W     = $clog2(BLOCK_BYTES),
  localparam int SEC_OFF_W = $clog2(SECTOR_BYTES),
  localparam int SLOT_W    = SEC_OFF_W - OFF_W,
  localparam int SEC_W     = $clog2(NUM_SECTORS),
  localparam int BLK_W     = SEC_W + SLOT_W,
  localparam int ADDR_W    = SEC_W + SEC_OFF_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BLK_W-1:0]  reqBlock,
  output logic              reqReady,
  input  logic              inValid,
  input  logic [7:0]        inData,
  output logic              inReady,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              done,
  output logic [ADDR_W-1:0] flAddr,
  output logic              flRead,
  input  logic [7:0]        flRdData,
  output logic              flErase,
  output logic              flProg,
  output logic [7:0]        flWrData,
  input  logic              flBusy
);

  strobe_t st;
  logic    cntLastBlk;
  logic    cntLastSec;

  sector_rmw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqReady(reqReady),
    .inValid(inValid), .inReady(inReady),
    .flBusy(flBusy),
    .cntLastBlk(cntLastBlk), .cntLastSec(cntLastSec),
    .done(done), .st(st)
  );

  sector_rmw_datapath #(
    .BLOCK_BYTES(BLOCK_BYTES), .SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st),
    .reqBlock(reqBlock), .inData(inData), .flRdData(flRdData),
    .flAddr(flAddr), .flWrData(flWrData),
    .outValid(outValid), .outData(outData),
    .cntLastBlk(cntLastBlk), .cntLastSec(cntLastSec)
  );

  assign flRead  = st.blkRd | st.secRd;
  assign flErase = st.erase;
  assign flProg  = st.prog;

  AST_NO_STROBE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !(flRead || flErase || flProg));             // R7

endmodule

// File: tb/sector_rmw_engine_bench.sv
module sector_rmw_engine_bench;

  localparam int NSEC    = 2;
  localparam int SECB    = 4096;
  localparam int BLKB    = 512;
  localparam int MEMB    = NSEC * SECB;
  localparam int BLK_W   = 4;
  localparam int ADDR_W  = 13;
  localparam int ERASE_T = 20;
  localparam int PROG_T  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [BLK_W-1:0] reqBlock = '0;
  logic reqReady;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, outValid, done;
  logic [7:0] outData;
  logic [ADDR_W-1:0] flAddr;
  logic flRead, flErase, flProg, flBusy;
  logic [7:0] flRdData, flWrData;

  always #10 clk = ~clk;

  sector_rmw_engine #(.BLOCK_BYTES(BLKB), .SECTOR_BYTES(SECB), .NUM_SECTORS(NSEC)) u_sector_rmw_engine (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqBlock(reqBlock), .reqReady(reqReady),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .done(done),
    .flAddr(flAddr), .flRead(flRead), .flRdData(flRdData),
    .flErase(flErase), .flProg(flProg), .flWrData(flWrData), .flBusy(flBusy)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] mem  [MEMB];
  logic [7:0] refM [MEMB];
  bit         programmed [MEMB];
  int busyCnt = 0;
  int rdCnt, eraseCnt, progCnt, rdAfterErase, progBusy, eraseBusy, dblProg, progNoErase, progOrder;
  bit phaseErased;
  int nextProg;

  assign flBusy = (busyCnt != 0);

  task automatic clrStats();
    rdCnt = 0; eraseCnt = 0; progCnt = 0; rdAfterErase = 0; progBusy = 0;
    eraseBusy = 0; dblProg = 0; progNoErase = 0; progOrder = 0;
    phaseErased = 1'b0; nextProg = 0;
  endtask

  always @(posedge clk) begin
    if (busyCnt > 0) busyCnt <= busyCnt - 1;
    if (flRead) begin
      flRdData <= mem[flAddr];
      rdCnt++;
      if (phaseErased) rdAfterErase++;
    end
    if (flErase) begin
      if (busyCnt != 0) eraseBusy++;
      eraseCnt++;
      for (int i = 0; i < SECB; i++) begin
        mem[{flAddr[ADDR_W-1], 12'(i)}] <= 8'hFF;
        programmed[{flAddr[ADDR_W-1], 12'(i)}] = 1'b0;
      end
      phaseErased = 1'b1;
      nextProg = int'(flAddr[ADDR_W-1]) * SECB;
      busyCnt <= ERASE_T;
    end
    if (flProg) begin
      if (busyCnt != 0) progBusy++;
      if (programmed[flAddr]) dblProg++;
      if (!phaseErased) progNoErase++;
      if (int'(flAddr) != nextProg) progOrder++;
      mem[flAddr] <= mem[flAddr] & flWrData;
      programmed[flAddr] = 1'b1;
      nextProg++;
      progCnt++;
      busyCnt <= PROG_T;
    end
  end

  // ---------------- scoreboard monitor ----------------
  logic [7:0] expQ [$];
  int doneCnt = 0;
  bit donePrev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (outValid) begin
        if (expQ.size() == 0) check(1'b0, "R7 unexpected outValid", 1, 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(outData == e, "R2 read byte", int'(outData), int'(e));
        end
      end
      if (done) begin
        doneCnt++;
        check(expQ.size() == 0, "R8 done after last byte", expQ.size(), 0);
        check(!donePrev, "R8 done one cycle", 1, 0);
      end
      donePrev = done;
    end
  end

  // ---------------- driver tasks ----------------
  task automatic waitDone(input int d0);
    while (doneCnt == d0) @(negedge clk);
    check(reqReady == 1'b1, "R8 ready after done", int'(reqReady), 1);
  endtask

  task automatic doRead(input int b);
    int d0;
    for (int i = 0; i < BLKB; i++) expQ.push_back(refM[b*BLKB + i]);
    @(negedge clk);
    clrStats();
    d0 = doneCnt;
    reqValid = 1'b1; reqWrite = 1'b0; reqBlock = BLK_W'(b);
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(d0);
    check(rdCnt == BLKB, "R2 read count", rdCnt, BLKB);
    check(eraseCnt == 0 && progCnt == 0, "R2 no erase/program on read", eraseCnt + progCnt, 0);
  endtask

  task automatic doWrite(input int b, input int seed, input bit gaps);
    int d0;
    int mism;
    @(negedge clk);
    clrStats();
    d0 = doneCnt;
    reqValid = 1'b1; reqWrite = 1'b1; reqBlock = BLK_W'(b);
    @(negedge clk);
    // stray request while busy: must be ignored
    reqWrite = 1'b0; reqBlock = BLK_W'(b ^ 1);
    for (int k = 0; k < 3; k++) begin
      check(!reqReady, "R7 ready low while busy", int'(reqReady), 0);
      check(!inReady, "R9 inReady low during copy", int'(inReady), 0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    for (int i = 0; i < BLKB; i++) begin
      logic [7:0] d;
      d = 8'(i * 13 + seed);
      refM[b*BLKB + i] = d;
      if (gaps && (i % 50 == 7)) begin
        inValid = 1'b0;
        @(negedge clk);
        check(inReady, "R9 inReady holds over gap", int'(inReady), 1);
        @(negedge clk);
      end
      inValid = 1'b1; inData = d;
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    waitDone(d0);
    check(rdCnt == SECB, "R3 sector copy reads", rdCnt, SECB);
    check(rdAfterErase == 0, "R3 no read after erase", rdAfterErase, 0);
    check(eraseCnt == 1, "R3 one erase", eraseCnt, 1);
    check(progNoErase == 0, "R3 program before erase", progNoErase, 0);
    check(progOrder == 0, "R3 program order", progOrder, 0);
    check(progBusy == 0 && eraseBusy == 0, "R4 strobe while busy", progBusy + eraseBusy, 0);
    check(progCnt == SECB, "R6 program count", progCnt, SECB);
    check(dblProg == 0, "R6 double program", dblProg, 0);
    @(negedge clk);
    mism = 0;
    for (int a = 0; a < MEMB; a++) if (mem[a] !== refM[a]) mism++;
    check(mism == 0, "R5 flash contents", mism, 0);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    for (int i = 0; i < MEMB; i++) begin
      mem[i] = 8'(i * 7 + 3);
      refM[i] = 8'(i * 7 + 3);
      programmed[i] = 1'b1;
    end
    clrStats();
    repeat (3) @(negedge clk);
    check(reqReady && !outValid && !done && !inReady, "R1 outputs in reset",
          {reqReady, outValid, done, inReady}, 8);
    rst_n = 1'b1;
    @(negedge clk);
    check(reqReady && !outValid && !done && !inReady, "R1 outputs after reset",
          {reqReady, outValid, done, inReady}, 8);
    check(!flRead && !flErase && !flProg, "R1 flash idle", {flRead, flErase, flProg}, 0);

    doRead(3);                 // R2 untouched block
    doWrite(10, 5, 1'b1);      // R3 R5 R9 sector 1 slot 2 with gaps
    doRead(10);                // R5 merged block
    doRead(8);                 // R5 neighbour in same sector
    doWrite(0, 91, 1'b0);      // R3 first slot
    doWrite(15, 200, 1'b0);    // R3 last slot
    doRead(15);
    doRead(0);
    doRead(11);

    repeat (5) @(negedge clk);
    check(rdCnt == BLKB, "R7 stray request started nothing", rdCnt, BLKB);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", doneCnt, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule